// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA Engine

This block feeds a transmit MAC from a linked list of descriptors in system memory. Each descriptor is three consecutive 32-bit words: a link to the next descriptor, a command/status word, and a byte pointer to one data fragment. When software raises the start command, the engine loads the current descriptor into a local cache. It then copies the fragment into a byte-wide transmit FIFO, handling any starting or ending byte alignment itself. Afterwards it writes the upper half of the command/status word back to memory, either to hand the descriptor back or to report packet completion. Finally it follows the link.

A zero link parks the engine in a suspended state. Software may then append descriptors and raise the start command again. A "current descriptor done" flag decides the resume path. When the flag is set, the engine re-reads the link of the descriptor it finished and follows it. When a new pointer has been written since, the flag is clear and the engine fetches at that pointer instead. A descriptor that the engine does not own also suspends it, with the flag clear, so that a later start re-reads the same descriptor.

Top module: `txd_chain_dma`

## Requirements
- R1: After reset the state code is 0 (idle), no memory request or FIFO push is active, and the start command is not pending.
- R2: A register write with `reg_sel`=1 and `reg_wdata[0]`=1 makes `en_pending` 1 on the next cycle. The bit clears by itself in the cycle after the engine accepts it in the idle or suspended state.
- R3: On a start the engine reads the descriptor words at offsets +0 (link), +4 (command/status) and +8 (fragment pointer), in that order, before any data read or push. Every memory request holds its address and direction until `mem_ack`.
- R4: The engine pushes exactly SIZE bytes, SIZE being command bits [11:0], starting at the fragment byte address, which may have any alignment. Data is read as aligned words, and byte k of a word is bits [8k+7:8k]. No push happens while `fifo_full` is 1, and a zero SIZE pushes nothing.
- R5: `fifo_eop` is 1 only with the last byte pushed for a descriptor whose "more" bit (command bit 30) is 0.
- R6: For a descriptor with "more" set, the engine writes to offset +4 with byte enables 1100 right after its data. The upper half written equals the cached upper half with bit 31 (ownership) cleared. It does not wait for `tx_done`.
- R7: For a descriptor with "more" clear, the engine waits for `tx_done` and then writes to offset +4 with enables 1100. The written bits are: 31 = 0, 30 and 27:16 as cached, 29 = `tx_ok`, 28 = 1.
- R8: After the write-back, a non-zero link makes the engine fetch the linked descriptor.
- R9: After the write-back, a zero link puts the engine in the suspended state (code 5) with the done flag set.
- R10: A start while the done flag is set reads the link word (+0) of the current descriptor. A non-zero value is fetched next. A zero value leaves the engine suspended.
- R11: A pointer write (`reg_sel`=0) in the idle or suspended state clears the done flag, and the next start fetches the descriptor at the written address.
- R12: A fetched descriptor with ownership bit 31 clear causes no push and no write. The engine suspends, and the next start fetches that same descriptor again.
- R13: Pointer writes made outside the idle and suspended states are ignored.
- R14: `state_o` reports 0 idle, 1 fetching (including the link re-read), 2 moving data, 3 waiting for completion, 4 writing back, 5 suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: descriptor pointer, 1: command (bit 0 = start) |
| reg_wdata | input | 32 | Register write data |
| en_pending | output | 1 | Start command raised and not yet accepted |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| fifo_push | output | 1 | Push one byte into the transmit FIFO |
| fifo_data | output | 8 | Pushed byte |
| fifo_eop | output | 1 | Pushed byte ends the packet |
| fifo_full | input | 1 | FIFO cannot take a byte |
| tx_done | input | 1 | One-cycle pulse: packet finished on the wire |
| tx_ok | input | 1 | Packet result, valid with `tx_done` |
| state_o | output | 3 | Engine state code |

## Verification
The data path is tried with fragments that start on each byte lane, end mid-word and cross a word boundary, with a single-byte fragment and with a zero-length middle fragment. These tell correct lane selection and word stepping apart from off-by-one counting. Backpressure comes from interleaved memory-acknowledge stalls and FIFO-full cycles, which separate a held request from a dropped or repeated one. The chain is built so that the two resume paths, the null re-read, a not-owned descriptor and a pointer write during a transfer each give a distinct expected address sequence.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = WORD_W / 8;
  // bit positions inside the upper half of the command/status word
  localparam int HI_OWN  = 15;
  localparam int HI_MORE = 14;
  localparam int HI_OK   = 13;
  localparam int HI_CMPL = 12;

  typedef enum logic [3:0] {
    S_IDLE, S_RELINK, S_LINK, S_CMD, S_PTR, S_XFER, S_WAIT, S_WB, S_SUSP
  } txd_state_e;

  function automatic logic [2:0] status_code(txd_state_e s);
    case (s)
      S_IDLE:                        status_code = 3'd0;
      S_RELINK, S_LINK, S_CMD, S_PTR: status_code = 3'd1;
      S_XFER:                        status_code = 3'd2;
      S_WAIT:                        status_code = 3'd3;
      S_WB:                          status_code = 3'd4;
      default:                       status_code = 3'd5;
    endcase
  endfunction

  function automatic logic [7:0] byte_lane(logic [WORD_W-1:0] w, logic [1:0] lane);
    byte_lane = w[{lane, 3'b000} +: 8];
  endfunction

  function automatic logic [15:0] wb_upper(logic [15:0] hi, logic ok, logic last);
    logic [15:0] r;
    r = hi;
    r[HI_OWN] = 1'b0;
    if (last) begin
      r[HI_OK]   = ok;
      r[HI_CMPL] = 1'b1;
    end
    wb_upper = r;
  endfunction
endpackage

// File: rtl/txd_cmd_regs.sv
module txd_cmd_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_we,
  input  logic reg_sel,
  input  logic en_bit,
  input  logic en_take,
  output logic en_pending,
  output logic ptr_wr
);
  logic en_set;

  assign en_set = reg_we && reg_sel && en_bit;
  assign ptr_wr = reg_we && !reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_pending <= 1'b0;
    else if (en_set)  en_pending <= 1'b1;
    else if (en_take) en_pending <= 1'b0;
  end

  p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_set |=> en_pending);
  p_en_selfclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_take && !en_set) |=> !en_pending);
endmodule

// File: rtl/txd_byte_align.sv
module txd_byte_align import txd_pkg::*; #(
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] start_ptr,
  input  logic [SIZE_W-1:0] start_size,
  input  logic              start_last,
  input  logic              rd_ack,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              fifo_full,
  output logic              rd_req,
  output logic [WORD_W-1:0] rd_addr,
  output logic              push,
  output logic [7:0]        push_data,
  output logic              push_eop,
  output logic              done
);
  logic              busy, have, last;
  logic [WORD_W-1:0] bptr, wbuf;
  logic [SIZE_W-1:0] rem;
  logic              rem_zero;

  assign rem_zero  = (rem == '0);
  assign rd_req    = busy && !have && !rem_zero;
  assign rd_addr   = {bptr[WORD_W-1:2], 2'b00};
  assign push      = busy && have && !rem_zero && !fifo_full;
  assign push_data = byte_lane(wbuf, bptr[1:0]);
  assign push_eop  = push && last && (rem == SIZE_W'(1));
  assign done      = busy && rem_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; have <= 1'b0; last <= 1'b0;
      bptr <= '0;   wbuf <= '0;   rem  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      have <= 1'b0;
      last <= start_last;
      bptr <= start_ptr;
      rem  <= start_size;
    end else begin
      if (done) busy <= 1'b0;
      if (rd_req && rd_ack) begin
        wbuf <= rd_data;
        have <= 1'b1;
      end
      if (push) begin
        bptr <= bptr + WORD_W'(1);
        rem  <= rem - SIZE_W'(1);
        if (bptr[1:0] == 2'b11) have <= 1'b0;
      end
    end
  end

  p_push_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !fifo_full);
  p_eop_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_eop |-> (push && last));
  p_no_read_while_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && bptr[1:0] != 2'b11) |=> !rd_req);
endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl import txd_pkg::*; #(
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_pending,
  input  logic              ptr_wr,
  input  logic [WORD_W-1:0] ptr_val,
  output logic              en_take,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_be,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              al_rd_req,
  input  logic [WORD_W-1:0] al_rd_addr,
  input  logic              al_done,
  output logic              al_start,
  output logic [WORD_W-1:0] al_ptr,
  output logic [SIZE_W-1:0] al_size,
  output logic              al_last,
  output logic              al_rd_ack,
  input  logic              tx_done,
  input  logic              tx_ok,
  output logic [2:0]        state_o
);
  txd_state_e        st, st_nx;
  logic [WORD_W-1:0] cur_ptr, c_link;
  logic [15:0]       c_hi;
  logic [SIZE_W-1:0] c_size;
  logic              cdd, ok_q;
  logic              idle_like, ptr_acc, acc, link_null, rd_null;

  assign idle_like = (st == S_IDLE) || (st == S_SUSP);
  assign ptr_acc   = ptr_wr && idle_like;
  assign en_take   = en_pending && idle_like;
  assign acc       = mem_req && mem_ack;
  assign link_null = (c_link == '0);
  assign rd_null   = (mem_rdata == '0);
  assign state_o   = status_code(st);

  assign al_start  = (st == S_PTR) && acc && c_hi[HI_OWN];
  assign al_ptr    = mem_rdata;
  assign al_size   = c_size;
  assign al_last   = !c_hi[HI_MORE];
  assign al_rd_ack = (st == S_XFER) && mem_ack && al_rd_req;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr;
    mem_wdata = '0;
    mem_be    = '1;
    case (st)
      S_RELINK, S_LINK: mem_req = 1'b1;
      S_CMD: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + WORD_W'(4);
      end
      S_PTR: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + WORD_W'(8);
      end
      S_XFER: begin
        mem_req  = al_rd_req;
        mem_addr = al_rd_addr;
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr + WORD_W'(4);
        mem_be    = {{(LANES-2){1'b1}}, 2'b00};
        mem_wdata = {wb_upper(c_hi, ok_q, !c_hi[HI_MORE]), 16'h0000};
      end
      default: ;
    endcase
  end

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE, S_SUSP: if (en_pending) st_nx = (cdd && !ptr_acc) ? S_RELINK : S_LINK;
      S_RELINK:       if (acc) st_nx = rd_null ? S_SUSP : S_LINK;
      S_LINK:         if (acc) st_nx = S_CMD;
      S_CMD:          if (acc) st_nx = S_PTR;
      S_PTR:          if (acc) st_nx = c_hi[HI_OWN] ? S_XFER : S_SUSP;
      S_XFER:         if (al_done) st_nx = c_hi[HI_MORE] ? S_WB : S_WAIT;
      S_WAIT:         if (tx_done) st_nx = S_WB;
      S_WB:           if (acc) st_nx = link_null ? S_SUSP : S_LINK;
      default:        st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur_ptr <= '0; c_link <= '0; c_hi <= '0;
      c_size <= '0; cdd <= 1'b0; ok_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (ptr_acc) begin
        cur_ptr <= ptr_val;
        cdd     <= 1'b0;
      end
      case (st)
        S_RELINK: if (acc && !rd_null) begin
          cur_ptr <= mem_rdata;
          cdd     <= 1'b0;
        end
        S_LINK: if (acc) c_link <= mem_rdata;
        S_CMD: if (acc) begin
          c_hi   <= mem_rdata[WORD_W-1:16];
          c_size <= mem_rdata[SIZE_W-1:0];
        end
        S_PTR: if (acc && !c_hi[HI_OWN]) cdd <= 1'b0;
        S_WAIT: if (tx_done) ok_q <= tx_ok;
        S_WB: if (acc) begin
          cdd <= link_null;
          if (!link_null) cur_ptr <= c_link;
        end
        default: ;
      endcase
    end
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_wait_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && tx_done) |=> (st == S_WB));
  p_align_in_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    al_rd_req |-> (st == S_XFER));
  p_ptr_ignored_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && st inside {S_LINK, S_CMD, S_PTR, S_XFER, S_WAIT}) |=> $stable(cur_ptr));
  p_null_suspend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB && acc && link_null) |=> (st == S_SUSP && cdd));
endmodule

// File: rtl/txd_chain_dma.sv
module txd_chain_dma import txd_pkg::*; #(
  parameter int SIZE_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic        en_pending,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        fifo_push,
  output logic [7:0]  fifo_data,
  output logic        fifo_eop,
  input  logic        fifo_full,
  input  logic        tx_done,
  input  logic        tx_ok,
  output logic [2:0]  state_o
);
  logic              en_take, ptr_wr;
  logic              al_start, al_last, al_rd_ack, al_rd_req, al_done;
  logic [WORD_W-1:0] al_ptr, al_rd_addr;
  logic [SIZE_W-1:0] al_size;

  txd_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .en_bit(reg_wdata[0]), .en_take(en_take),
    .en_pending(en_pending), .ptr_wr(ptr_wr)
  );

  txd_ctrl #(.SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_pending(en_pending), .ptr_wr(ptr_wr),
    .ptr_val(reg_wdata), .en_take(en_take),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .al_rd_req(al_rd_req), .al_rd_addr(al_rd_addr),
    .al_done(al_done), .al_start(al_start), .al_ptr(al_ptr),
    .al_size(al_size), .al_last(al_last), .al_rd_ack(al_rd_ack),
    .tx_done(tx_done), .tx_ok(tx_ok), .state_o(state_o)
  );

  txd_byte_align #(.SIZE_W(SIZE_W)) u_align (
    .clk(clk), .rst_n(rst_n), .start(al_start), .start_ptr(al_ptr),
    .start_size(al_size), .start_last(al_last), .rd_ack(al_rd_ack),
    .rd_data(mem_rdata), .fifo_full(fifo_full), .rd_req(al_rd_req),
    .rd_addr(al_rd_addr), .push(fifo_push), .push_data(fifo_data),
    .push_eop(fifo_eop), .done(al_done)
  );
endmodule

// File: tb/txd_chain_dma_bench.sv
`timescale 1ns/1ps
module txd_chain_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        en_pending, mem_req, mem_we, fifo_push, fifo_eop;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0, fifo_full = 1'b0, tx_done = 1'b0, tx_ok = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [7:0]  fifo_data;
  logic [2:0]  state_o;

  always #5 clk = ~clk;

  txd_chain_dma u_txd_chain_dma (.*);

  logic [31:0] mem [0:255];
  int unsigned q_rd[$];
  int unsigned q_wa[$];
  logic [15:0] q_wd[$];
  logic [8:0]  q_by[$];
  logic        q_ok[$];
  int compared = 0, mismatched = 0, cyc = 0, wcnt = 0;
  bit done_flag = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // memory, FIFO and MAC models; reference queues compared every clock
  always begin
    @(negedge clk);
    cyc++;
    fifo_full = ((cyc % 7) == 3) || ((cyc % 11) == 5);
    mem_ack   = mem_req && ((cyc % 3) != 1);
    mem_rdata = mem[mem_addr[9:2]];
    if (state_o == 3'd3) begin
      wcnt++;
      if (wcnt == 3) begin
        tx_done = 1'b1;
        tx_ok   = (q_ok.size() != 0) ? q_ok.pop_front() : 1'b0;
        wcnt    = 0;
      end else tx_done = 1'b0;
    end else begin
      tx_done = 1'b0;
      wcnt    = 0;
    end
    #4;
    if (rst_n) begin
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          if (q_wa.size() == 0) chk(0, "R6/R7", "unexpected write", mem_addr, 0);
          else begin
            int unsigned a;
            logic [15:0] d;
            a = q_wa.pop_front();
            d = q_wd.pop_front();
            chk(mem_addr == a && mem_wdata[31:16] == d, "R6/R7", "writeback addr:data",
                {mem_addr[15:0], mem_wdata[31:16]}, {a[15:0], d});
            chk(mem_be == 4'b1100, "R6/R7", "byte enables", mem_be, 4'b1100);
          end
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[mem_addr[9:2]][8*k +: 8] = mem_wdata[8*k +: 8];
        end else begin
          if (q_rd.size() == 0) chk(0, "R3/R8/R10", "unexpected read", mem_addr, 0);
          else begin
            int unsigned e;
            e = q_rd.pop_front();
            chk(mem_addr == e, "R3/R8/R10", "read address", mem_addr, e);
          end
        end
      end
      if (fifo_push) begin
        chk(!fifo_full, "R4", "push while full", 1, 0);
        if (q_by.size() == 0) chk(0, "R4/R5", "unexpected push", {fifo_eop, fifo_data}, 0);
        else begin
          logic [8:0] e;
          e = q_by.pop_front();
          chk({fifo_eop, fifo_data} == e, "R4/R5", "eop:byte", {fifo_eop, fifo_data}, e);
        end
      end
    end
  end

  task automatic set_desc(int unsigned d, int unsigned link, bit own, bit more,
                          int unsigned size, int unsigned fp);
    mem[d >> 2]       = link;
    mem[(d + 4) >> 2] = {own, more, 2'b00, 12'hA5C, 4'h0, size[11:0]};
    mem[(d + 8) >> 2] = fp;
  endtask

  task automatic exp_fetch(int unsigned d);
    q_rd.push_back(d);
    q_rd.push_back(d + 4);
    q_rd.push_back(d + 8);
  endtask

  task automatic exp_desc(int unsigned d, bit ok);
    logic [31:0] cmd, w;
    logic [15:0] hi;
    int unsigned fp, n;
    exp_fetch(d);
    cmd = mem[(d + 4) >> 2];
    fp  = mem[(d + 8) >> 2];
    n   = cmd[11:0];
    if (n > 0)
      for (int unsigned a = fp >> 2; a <= (fp + n - 1) >> 2; a++) q_rd.push_back(a << 2);
    for (int unsigned i = 0; i < n; i++) begin
      w = mem[((fp + i) >> 2) & 8'hFF];
      q_by.push_back({!cmd[30] && (i == n - 1), w[8 * ((fp + i) % 4) +: 8]});
    end
    hi = cmd[31:16];
    hi[15] = 1'b0;
    if (!cmd[30]) begin
      hi[13] = ok;
      hi[12] = 1'b1;
      q_ok.push_back(ok);
    end
    q_wa.push_back(d + 4);
    q_wd.push_back(hi);
  endtask

  task automatic reg_write(bit sel, logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic en_cmd();
    reg_write(1'b1, 32'h1);
    chk(en_pending == 1'b1, "R2", "start pending", en_pending, 1);
  endtask

  task automatic wait_quiet(string tag);
    int n = 0;
    repeat (8) @(negedge clk);
    while ((q_rd.size() != 0 || q_wa.size() != 0 || q_by.size() != 0 || state_o != 3'd5)
           && n < 4000) begin
      @(negedge clk);
      n++;
    end
    #6;
    chk(q_rd.size() + q_wa.size() + q_by.size() == 0, tag, "events left",
        q_rd.size() + q_wa.size() + q_by.size(), 0);
    chk(state_o == 3'd5, "R9/R14", "suspended code", state_o, 5);
    chk(en_pending == 1'b0, "R2", "start self-cleared", en_pending, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++)
      for (int k = 0; k < 4; k++) mem[i][8*k +: 8] = 8'((i * 4 + k) * 7 + 3);
    set_desc(32'h40, 32'h50, 1, 1, 5, 32'h101);
    set_desc(32'h50, 32'h60, 1, 0, 6, 32'h203);
    set_desc(32'h60, 32'h00, 1, 0, 4, 32'h2F0);
    set_desc(32'h70, 32'h00, 1, 0, 1, 32'h2A7);
    set_desc(32'h80, 32'h90, 0, 1, 7, 32'h3F8);
    set_desc(32'h90, 32'hA0, 1, 1, 0, 32'h150);
    set_desc(32'hA0, 32'h00, 1, 0, 3, 32'h1FE);
    set_desc(32'hB0, 32'h00, 1, 0, 9, 32'h161);

    repeat (3) @(negedge clk);
    #4;
    chk(state_o == 3'd0, "R1/R14", "reset state", state_o, 0);
    chk(mem_req == 1'b0 && fifo_push == 1'b0, "R1", "idle outputs", {mem_req, fifo_push}, 0);
    chk(en_pending == 1'b0, "R1", "reset pending", en_pending, 0);
    rst_n = 1'b1;

    // multi-descriptor packet then single packet, null link
    exp_desc(32'h40, 0);
    exp_desc(32'h50, 1);
    exp_desc(32'h60, 0);
    reg_write(1'b0, 32'h40);
    en_cmd();
    wait_quiet("R3/R4/R5/R6/R7/R8");

    // append after suspend: link re-read of current descriptor
    set_desc(32'h70, 32'h00, 1, 0, 1, 32'h2A7);
    mem[32'h60 >> 2] = 32'h70;
    q_rd.push_back(32'h60);
    exp_desc(32'h70, 1);
    en_cmd();
    wait_quiet("R10");

    // resume with nothing appended
    q_rd.push_back(32'h70);
    en_cmd();
    wait_quiet("R10");

    // new pointer at a descriptor not owned
    reg_write(1'b0, 32'h80);
    exp_fetch(32'h80);
    en_cmd();
    wait_quiet("R11/R12");

    // same descriptor handed over; pointer write during transfer is ignored
    mem[32'h84 >> 2][31] = 1'b1;
    exp_desc(32'h80, 0);
    exp_desc(32'h90, 0);
    exp_desc(32'hA0, 1);
    en_cmd();
    while (state_o != 3'd2) @(negedge clk);
    reg_write(1'b0, 32'h380);
    wait_quiet("R4/R12/R13");

    mem[32'hA0 >> 2] = 32'hB0;
    q_rd.push_back(32'hA0);
    exp_desc(32'hB0, 0);
    en_cmd();
    wait_quiet("R10/R13");

    finish_run();
  end
endmodule